// File: doc/BRIEF.md
# Five-State One-Hot Controller with Zero-Start Recovery

This block is a small synchronous controller with five states, each held in its own flip-flop. Two control inputs, `s_in` and `t_in`, steer it between the states. It drives two outputs, `p_out` and `q_out`, which depend on both the current state and the present inputs.

Reset only clears flip-flops; no flip-flop is ever preset. After reset, every state bit is therefore 0. A wide all-zero detector makes that empty vector behave as the first state (state a). On the first active clock edge the controller takes state a's own arcs, so it always enters a legal one-hot state after one cycle.

The next value of each state bit is the OR of one term per incoming arc. Each term is the source state bit ANDed with that arc's condition on the inputs. All arc conditions are held in a single parameter, so their polarities can be changed in one place.

Top module: `ohz_fsm`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state vector becomes 5'b00000 and stays there. Bit 0 is state a, bit 1 is b, bit 2 is c, bit 3 is d and bit 4 is e.
- R2: From the all-zero vector with `rst_n` high, the next edge moves the machine to state a (5'b00001) if `s_in`=0, and to state b (5'b00010) if `s_in`=1, whatever `t_in` is.
- R3: Once the machine has left the all-zero vector, exactly one state bit is 1 on every cycle until reset is applied again.
- R4: In state a, `s_in`=0 keeps the machine in a and `s_in`=1 moves it to b.
- R5: In state b or state c, the next state is chosen as follows: `s_in`=1 goes to b; `s_in`=0 with `t_in`=1 goes to c; `s_in`=0 with `t_in`=0 goes to e.
- R6: In state d, `s_in`=1 with `t_in`=1 goes to c; every other input pair goes to e.
- R7: In state e, `s_in`=1 with `t_in`=1 goes to a; every other input pair goes to d.
- R8: `p_out` is 1 exactly when the state is e and `s_in` is 0, in the same cycle, with no register in between.
- R9: `q_out` is 1 exactly when the state is d and both `s_in` and `t_in` are 1, in the same cycle, with no register in between.
- R10: While the state vector is all zero, `p_out` and `q_out` are both 0 for every input pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; clears every state bit |
| s_in | input | 1 | First steering input |
| t_in | input | 1 | Second steering input |
| state_o | output | 5 | One-hot state vector, bit 0 = a through bit 4 = e; all zero after reset |
| p_out | output | 1 | Combinational output, active in state e when `s_in` is 0 |
| q_out | output | 1 | Combinational output, active in state d when `s_in` and `t_in` are both 1 |

## Verification
The machine is first held in reset with every input pair applied, to show that the cleared vector keeps both outputs low. Reset is then released twice, once with `s_in` low and once with it high, which tells apart a zero state that imitates state a from one that only ever jumps to a. A directed walk then takes every one of the twelve arcs. This isolates any single arc whose condition polarity or destination is wrong, and it exposes both outputs in the states that enable them and the states that do not. A long run of random input pairs follows. A behavioural model is compared with the design on every cycle, to catch lost or duplicated hot bits and output errors that depend on the order of arcs.

// File: rtl/ohz_pkg.sv
// Package ohz_pkg
// Shared sizes, state indices and arc topology of the five-state one-hot
// controller. The arc list fixes only where each arc starts and ends; the
// input condition of each arc is a parameter of the top module.
package ohz_pkg;

    localparam int N_STATES = 5;
    localparam int N_ARCS   = 12;
    localparam int COND_W   = 4;   // truth table over {s,t}, index = {s,t}

    localparam int ST_A = 0;
    localparam int ST_B = 1;
    localparam int ST_C = 2;
    localparam int ST_D = 3;
    localparam int ST_E = 4;

    // Source and destination state of every arc, arc k at position k.
    localparam int ARC_SRC [N_ARCS] = '{ST_A, ST_A, ST_B, ST_B, ST_B, ST_C,
                                        ST_C, ST_C, ST_D, ST_D, ST_E, ST_E};
    localparam int ARC_DST [N_ARCS] = '{ST_A, ST_B, ST_B, ST_C, ST_E, ST_B,
                                        ST_C, ST_E, ST_C, ST_E, ST_A, ST_D};

    typedef logic [N_STATES-1:0] state_vec_t;

endpackage

// File: rtl/ohz_zero_detect.sv
// Module ohz_zero_detect
// Wide NOR across a vector: reports when no bit is set. Used to fold the
// cleared reset vector into the initial state. Assumes nothing about the
// vector's contents.
module ohz_zero_detect #(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic             all_zero_o
);

    // Reduce the whole vector to a single "nothing hot" flag.
    always_comb all_zero_o = ~|vec_i;

endmodule

// File: rtl/ohz_arc_eval.sv
// Module ohz_arc_eval
// Next-state logic read straight off the arc list: one AND term per arc
// (source bit and input condition), ORed per destination bit. Assumes the
// effective state vector it receives is one-hot; the conditions leaving
// each state must then cover every input pair exactly once.
module ohz_arc_eval
    import ohz_pkg::*;
#(
    parameter logic [N_ARCS-1:0][COND_W-1:0] ARC_COND = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  state_vec_t eff_state_i,
    input  logic       s_i,
    input  logic       t_i,
    output state_vec_t next_o
);

    logic [N_ARCS-1:0] arc_fire;
    logic [1:0]        in_idx;

    // Form the truth-table index from the two steering inputs.
    always_comb in_idx = {s_i, t_i};

    for (genvar k = 0; k < N_ARCS; k++) begin : g_arc
        // One product term: arc k fires when its source is hot and its condition holds.
        always_comb arc_fire[k] = eff_state_i[ARC_SRC[k]] & ARC_COND[k][in_idx];
    end

    // Collect every firing arc into the bit of its destination state.
    always_comb begin
        next_o = '0;
        for (int k = 0; k < N_ARCS; k++) begin
            if (arc_fire[k]) next_o[ARC_DST[k]] = 1'b1;
        end
    end

    // R3: a complete, exclusive table maps one hot source to one hot destination.
    p_table_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(eff_state_i) |-> $onehot(next_o))
        else $error("arc table not closed for current state and inputs");

endmodule

// File: rtl/ohz_state_reg.sv
// Module ohz_state_reg
// Bank of state flip-flops with a clear-only synchronous reset: no bit is
// ever preset, so the vector leaves reset as all zeros. Assumes rst_n is
// synchronous to clk.
module ohz_state_reg #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    // Capture the next state, or clear every bit under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= d_i;
    end

    // R3: the register never holds more than one hot bit.
    p_at_most_one_hot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_o))
        else $error("state register holds several hot bits");

endmodule

// File: rtl/ohz_fsm.sv
// Module ohz_fsm (top)
// Five-state one-hot controller with clear-only reset. The all-zero vector
// is ORed into state a's bit before the arc logic, so the cleared machine
// follows state a's arcs on its first active edge. Outputs are Mealy terms
// of the real (unfolded) state, so both stay low while the vector is zero.
// Assumes the arc conditions leave each state with exactly one arc per
// input pair.
module ohz_fsm
    import ohz_pkg::*;
#(
    // Arc k condition, bit {s,t} set when the arc is taken for that input pair.
    parameter logic [N_ARCS-1:0][COND_W-1:0] ARC_COND = {
        4'b0111,   // 11: e -> d unless s&t
        4'b1000,   // 10: e -> a on s&t
        4'b0111,   //  9: d -> e unless s&t
        4'b1000,   //  8: d -> c on s&t
        4'b0001,   //  7: c -> e on !s&!t
        4'b0010,   //  6: c -> c on !s&t
        4'b1100,   //  5: c -> b on s
        4'b0001,   //  4: b -> e on !s&!t
        4'b0010,   //  3: b -> c on !s&t
        4'b1100,   //  2: b -> b on s
        4'b1100,   //  1: a -> b on s
        4'b0011    //  0: a -> a on !s
    },
    parameter logic [COND_W-1:0] P_COND  = 4'b0011,  // p in state e when !s
    parameter logic [COND_W-1:0] Q_COND  = 4'b1000,  // q in state d when s&t
    parameter int                P_STATE = ST_E,
    parameter int                Q_STATE = ST_D
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s_in,
    input  logic                t_in,
    output logic [N_STATES-1:0] state_o,
    output logic                p_out,
    output logic                q_out
);

    state_vec_t state_q;
    state_vec_t state_eff;
    state_vec_t state_d;
    logic       is_zero;

    ohz_zero_detect #(.WIDTH(N_STATES)) u_zero (
        .vec_i      (state_q),
        .all_zero_o (is_zero)
    );

    // Treat the empty vector as state a for next-state purposes only.
    always_comb begin
        state_eff       = state_q;
        state_eff[ST_A] = state_q[ST_A] | is_zero;
    end

    ohz_arc_eval #(.ARC_COND(ARC_COND)) u_arcs (
        .clk         (clk),
        .rst_n       (rst_n),
        .eff_state_i (state_eff),
        .s_i         (s_in),
        .t_i         (t_in),
        .next_o      (state_d)
    );

    ohz_state_reg #(.WIDTH(N_STATES)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (state_d),
        .q_o   (state_q)
    );

    // Drive the Mealy outputs from the registered state and live inputs.
    always_comb begin
        state_o = state_q;
        p_out   = state_q[P_STATE] & P_COND[{s_in, t_in}];
        q_out   = state_q[Q_STATE] & Q_COND[{s_in, t_in}];
    end

    // R2: the cleared vector is left after exactly one active edge.
    p_leave_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == '0) |=> $onehot(state_q))
        else $error("machine stayed outside the one-hot set");

    // R7: state e with both inputs high returns to state a.
    p_e_returns_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q[ST_E] && s_in && t_in) |=> state_q[ST_A])
        else $error("e did not return to a");

    // R8: p is only raised on the e-to-d arc.
    p_p_leads_to_d_r8: assert property (@(posedge clk) disable iff (!rst_n)
        p_out |=> state_q[ST_D])
        else $error("p raised outside the e-to-d arc");

    // R9: q is only raised on the d-to-c arc.
    p_q_leads_to_c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q_out |=> state_q[ST_C])
        else $error("q raised outside the d-to-c arc");

endmodule

// File: tb/tb_ohz_fsm.sv
`timescale 1ns/1ps
module tb_ohz_fsm;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       s_in  = 1'b0;
    logic       t_in  = 1'b0;
    logic [4:0] state_o;
    logic       p_out;
    logic       q_out;

    int errors = 0;
    int checks = 0;
    int m      = -2;      // model state: -2 unknown, -1 all zero, 0..4 = a..e
    string tag = "R1";    // requirement that produced the current model state

    always #5 clk = ~clk;

    ohz_fsm dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_in    (s_in),
        .t_in    (t_in),
        .state_o (state_o),
        .p_out   (p_out),
        .q_out   (q_out)
    );

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b (time %0t)", req, act, exp, $time);
        end
    endtask

    // One clock: apply inputs at the falling edge, compare, then advance the model.
    task automatic step(input logic s, input logic t, input logic r);
        logic [4:0] exp_vec;
        logic       exp_p;
        logic       exp_q;
        @(negedge clk);
        rst_n = r;
        s_in  = s;
        t_in  = t;
        #1;
        if (m != -2) begin
            exp_vec = (m < 0) ? 5'b0 : 5'(1 << m);
            check(tag, state_o, exp_vec);
            if (m >= 0) check("R3", 5'($countones(state_o)), 5'd1);
            exp_p = (m == 4) && !s;
            exp_q = (m == 3) && s && t;
            check((m < 0) ? "R10" : "R8", {4'b0, p_out}, {4'b0, exp_p});
            check((m < 0) ? "R10" : "R9", {4'b0, q_out}, {4'b0, exp_q});
        end
        @(posedge clk);
        if (!r) begin
            m = -1; tag = "R1";
        end else begin
            case ((m < 0) ? 0 : m)
                0: tag = (m < 0) ? "R2" : "R4";
                1, 2: tag = "R5";
                3: tag = "R6";
                default: tag = "R7";
            endcase
            case ((m < 0) ? 0 : m)
                0:       m = s ? 1 : 0;
                1, 2:    m = s ? 1 : (t ? 2 : 4);
                3:       m = (s && t) ? 2 : 4;
                default: m = (s && t) ? 0 : 3;
            endcase
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1, R10: held in reset under every input pair.
        step(0, 0, 0); step(0, 1, 0); step(1, 0, 0); step(1, 1, 0);
        // R2: leave zero with s=0 -> a.
        step(0, 1, 1);
        // R4, R5, R6, R7: directed walk over every arc.
        step(0, 0, 1);   // a -> a
        step(1, 0, 1);   // a -> b
        step(1, 1, 1);   // b -> b
        step(0, 1, 1);   // b -> c
        step(1, 0, 1);   // c -> b
        step(0, 0, 1);   // b -> e
        step(0, 0, 1);   // e -> d
        step(0, 1, 1);   // d -> e
        step(1, 0, 1);   // e -> d
        step(1, 1, 1);   // d -> c, q high
        step(0, 1, 1);   // c -> c
        step(0, 0, 1);   // c -> e
        step(1, 1, 1);   // e -> a
        step(1, 1, 1);   // a -> b
        step(0, 0, 1);   // b -> e
        step(0, 1, 1);   // e -> d, p high
        step(1, 0, 1);   // d -> e
        step(1, 1, 1);   // e -> a
        step(0, 0, 1);
        // R2: leave zero with s=1 -> b.
        step(1, 1, 0);
        step(1, 0, 1);
        step(0, 0, 1);
        // R3, R8, R9: random input pairs.
        for (int i = 0; i < 600; i++) begin
            step(1'($urandom), 1'($urandom), 1'b1);
        end
        step(0, 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule